// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Flow Gating

This block is the transmit half of an asynchronous serial port. The host pushes bytes with a one-cycle write strobe into a 16-entry transmit queue. The block sends them on a single serial line as frames with one start bit, eight data bits and one stop bit. A 16x baud tick comes from outside and sets the bit timing. For polling, the host sees a not-full flag, the queue fill level, a sticky overflow flag and an idle flag.

A remote receiver can pause the line through an active-low clear-to-send input. That input passes through a two-flop synchronizer. Gating applies only while both the auto-flow enable and the queue enable are set. While gating applies and the synchronized clear-to-send is high, no new frame begins. Writes into the queue still go on. Between back-to-back frames, the choice to continue or to pause is made at the middle of the current frame's stop bit. A clear-to-send that rises after that point lets exactly one more frame go out. Transmission resumes by itself once clear-to-send is low again.

Top module: `uart_cts_tx`

## Requirements
- R1: After a synchronous active-low reset, `txd` is 1, `idle` is 1, `fifo_not_full` is 1, `fifo_level` is 0 and `overflow` is 0.
- R2: A frame is a start bit of value 0, then eight data bits sent least significant bit first, then a stop bit of value 1. Each bit lasts 16 pulses of `baud_tick16`. The line rests at 1 between frames.
- R3: Flow gating is active only when `auto_flow_en` and `fifo_en` are both 1. While gating is inactive, the level of `cts_n` has no effect on transmission.
- R4: While gating is active and the synchronized `cts_n` is 1, no new frame starts. From rest, a frame starts only if gating allows it in that cycle.
- R5: For back-to-back frames, the go/halt decision is taken on the 8th baud tick of the stop bit. If `cts_n` rises after that tick, exactly one more frame is sent before the line halts.
- R6: Writes while the line is halted are stored. `fifo_level` counts the stored bytes, and `fifo_not_full` is 0 exactly when the level equals 16.
- R7: A write while the queue holds 16 bytes is discarded and sets `overflow`, which stays 1 until reset. The stored bytes are not changed.
- R8: When `cts_n` returns to 0, the pending bytes are sent without any host action.
- R9: `idle` is 1 only when the queue is empty and no frame is on the line.
- R10: Bytes leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| fifo_en | input | 1 | Queue enable; one of the two conditions for flow gating |
| auto_flow_en | input | 1 | Auto-flow enable; the other condition for flow gating |
| cts_n | input | 1 | Asynchronous clear-to-send, active low |
| txd | output | 1 | Serial output line |
| fifo_not_full | output | 1 | 1 while the queue holds fewer than 16 bytes |
| fifo_level | output | 5 | Number of stored bytes |
| overflow | output | 1 | Sticky flag for a write that was discarded |
| idle | output | 1 | Queue empty and no frame in progress |

## Verification
The in-module assertions check on every cycle that:
- the fill level never exceeds the depth;
- the queue is never popped while empty;
- a discarded write leaves the level unchanged;
- overflow never clears;
- a frame leaves rest only with permission;
- a halt decision at mid stop bit means the line returns to rest.

Frame shape, bit order and byte order can only be shown by the scoreboard, which decodes the serial line. The same holds for the timing of a late clear-to-send relative to the stop-bit decision, for storage while halted, for the discarded write and for automatic resumption. The bench scenarios exercise each of these.

// File: rtl/uart_cts_pkg.sv
// Package: shared types for the clear-to-send gated serial transmitter.
// Assumes nothing beyond SystemVerilog 2017.
package uart_cts_pkg;
    // Phases of one outgoing frame.
    typedef enum logic [1:0] {
        TX_REST  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_phase_e;
endpackage

// File: rtl/cts_sync.sv
// Module: two-flop synchronizer for the clear-to-send input.
// Assumes the input is asynchronous to clk. Resets to 1, the inactive
// (stop-sending) level.
module cts_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic hold_q;

    // Purpose: move the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            hold_q <= 1'b1;
        end else begin
            meta_q <= async_i;
            hold_q <= meta_q;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/tx_queue.sv
// Module: transmit queue, a circular buffer with fill level and sticky overflow.
// Assumes DEPTH is a power of two. A push while full is dropped, even when
// a pop happens in the same cycle. A pop must only be issued while not empty.
module tx_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic              overflow_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [LVL_W-1:0]  level_q;
    logic              ovf_q;
    logic              accept;

    assign full_o  = (level_q == LVL_W'(DEPTH));
    assign empty_o = (level_q == '0);
    assign accept  = push_i && !full_o;
    assign head_o  = store_q[rd_ptr_q];
    assign level_o = level_q;
    assign overflow_o = ovf_q;

    // Purpose: write accepted bytes into storage (no reset needed for data).
    always_ff @(posedge clk) begin
        if (accept) begin
            store_q[wr_ptr_q] <= data_i;
        end
    end

    // Purpose: advance the pointers, track the level and latch overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (accept) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (pop_i) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            if (accept && !pop_i) begin
                level_q <= level_q + 1'b1;
            end else if (!accept && pop_i) begin
                level_q <= level_q - 1'b1;
            end
            if (push_i && full_o) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // R6: the level never passes the depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(DEPTH));

    // R10: a pop never takes from an empty queue
    a_r10_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    // R7: a push into a full queue leaves the level unchanged
    a_r7_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (level_q == $past(level_q)));

    // R7: overflow stays set
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
endmodule

// File: rtl/tx_framer.sv
// Module: frame engine. Serializes bytes from the queue as start, data
// (LSB first) and stop bits, each TICKS_PER_BIT baud ticks long.
// Assumes allow_i is already synchronized and that queue data is valid
// whenever empty_i is low. The next-frame decision is taken on tick
// number TICKS_PER_BIT/2 of the stop bit.
module tx_framer
    import uart_cts_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              allow_i,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] head_i,
    output logic              pop_o,
    output logic              txd_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(TICKS_PER_BIT/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    tx_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] next_q;
    logic              next_vld_q;
    logic              start_rest;
    logic              take_mid;
    logic              bit_end;

    assign bit_end    = tick_i && (cnt_q == LAST_CNT);
    assign start_rest = (phase_q == TX_REST) && !empty_i && allow_i;
    assign take_mid   = (phase_q == TX_STOP) && tick_i && (cnt_q == MID_CNT)
                        && !empty_i && allow_i && !next_vld_q;
    assign pop_o      = start_rest || take_mid;
    assign busy_o     = (phase_q != TX_REST);

    // Purpose: drive the line level from the current frame phase.
    always_comb begin
        unique case (phase_q)
            TX_START: txd_o = 1'b0;
            TX_DATA:  txd_o = shift_q[0];
            default:  txd_o = 1'b1;
        endcase
    end

    // Purpose: step the frame phases, count ticks and bits, shift the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= TX_REST;
            cnt_q      <= '0;
            bit_q      <= '0;
            shift_q    <= '0;
            next_q     <= '0;
            next_vld_q <= 1'b0;
        end else begin
            unique case (phase_q)
                TX_REST: begin
                    cnt_q <= '0;
                    if (start_rest) begin
                        shift_q <= head_i;
                        phase_q <= TX_START;
                    end
                end
                TX_START: begin
                    if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (bit_end) begin
                        bit_q   <= '0;
                        phase_q <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (bit_end) begin
                        shift_q <= shift_q >> 1;
                        if (bit_q == LAST_BIT) begin
                            phase_q <= TX_STOP;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (take_mid) begin
                        next_q     <= head_i;
                        next_vld_q <= 1'b1;
                    end
                    if (bit_end) begin
                        if (next_vld_q) begin
                            shift_q    <= next_q;
                            next_vld_q <= 1'b0;
                            phase_q    <= TX_START;
                        end else begin
                            phase_q <= TX_REST;
                        end
                    end
                end
                default: phase_q <= TX_REST;
            endcase
        end
    end

    // R4: a frame leaves rest only in a cycle where gating allowed it
    a_r4_start_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == TX_START && $past(phase_q) == TX_REST) |-> $past(allow_i));

    // R5: a halt decided at mid stop bit returns the line to rest after the stop bit
    a_r5_mid_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == TX_STOP && tick_i && cnt_q == MID_CNT && !allow_i && !next_vld_q)
        |=> !next_vld_q);

    // R2: the line is high outside start and data bits
    a_r2_line_high_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == TX_REST || phase_q == TX_STOP) |-> txd_o);
endmodule

// File: rtl/uart_cts_tx.sv
// Module: top of the serial transmitter with clear-to-send gating.
// Assumes baud_tick16 is a single-cycle pulse and that cts_n is asynchronous.
// Gating applies only when auto_flow_en and fifo_en are both set.
module uart_cts_tx #(
    parameter int DATA_W        = 8,
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    localparam int LVL_W        = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_en,
    input  logic              auto_flow_en,
    input  logic              cts_n,
    output logic              txd,
    output logic              fifo_not_full,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              overflow,
    output logic              idle
);
    logic              cts_hold;
    logic              gate_on;
    logic              allow;
    logic              pop;
    logic              q_empty;
    logic              q_full;
    logic              busy;
    logic [DATA_W-1:0] q_head;

    cts_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cts_n),
        .sync_o  (cts_hold)
    );

    tx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (wr_en),
        .data_i     (wr_data),
        .pop_i      (pop),
        .head_o     (q_head),
        .empty_o    (q_empty),
        .full_o     (q_full),
        .level_o    (fifo_level),
        .overflow_o (overflow)
    );

    tx_framer #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (baud_tick16),
        .allow_i (allow),
        .empty_i (q_empty),
        .head_i  (q_head),
        .pop_o   (pop),
        .txd_o   (txd),
        .busy_o  (busy)
    );

    assign gate_on       = auto_flow_en && fifo_en;
    assign allow         = !(gate_on && cts_hold);
    assign fifo_not_full = !q_full;
    assign idle          = q_empty && !busy;

    // R9: idle is never reported while a pop is taking a byte
    a_r9_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !pop);
endmodule

// File: tb/uart_cts_tx_tb_top.sv
// Bench: scoreboard. The write task queues expected bytes, and the monitor
// decodes the serial line and compares each frame against the queue.
module uart_cts_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_en = 1'b0;
    logic       auto_flow_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd;
    logic       fifo_not_full;
    logic [4:0] fifo_level;
    logic       overflow;
    logic       idle;

    int checks = 0;
    int failures = 0;
    int stops_seen = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q [$];

    uart_cts_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_en(fifo_en),
        .auto_flow_en(auto_flow_en), .cts_n(cts_n), .txd(txd),
        .fifo_not_full(fifo_not_full), .fifo_level(fifo_level),
        .overflow(overflow), .idle(idle)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Baud tick: one pulse every 4 clocks.
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            baud_tick16 <= 1'b1;
            @(posedge clk);
            baud_tick16 <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        exp_q.push_back(b);
    endtask

    task automatic put_dropped(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_stops(input int target);
        while (stops_seen < target) @(negedge clk);
    endtask

    // Monitor: decode frames sampled near each bit middle (64 clocks per bit).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                logic [7:0] got;
                repeat (31) @(negedge clk);
                check(txd == 1'b0, "R2 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (64) @(negedge clk);
                    got[i] = txd;
                end
                repeat (64) @(negedge clk);
                check(txd == 1'b1, "R2 stop bit", txd, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected frame", got, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R2/R10 frame data", got, e);
                end
                stops_seen++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(idle == 1'b1, "R1 idle", idle, 1);
        check(fifo_not_full == 1'b1, "R1 not_full", fifo_not_full, 1);
        check(fifo_level == 0, "R1 level", fifo_level, 0);
        check(overflow == 1'b0, "R1 overflow", overflow, 0);

        // R3: gating off, cts_n high is ignored
        put_byte(8'hA5);
        put_byte(8'h3C);
        put_byte(8'h81);
        repeat (100) @(negedge clk);
        check(idle == 1'b0, "R9 busy not idle", idle, 0);
        wait_stops(3);
        repeat (100) @(negedge clk);
        check(stops_seen == 3, "R3 cts ignored when disabled", stops_seen, 3);
        check(idle == 1'b1, "R9 idle after drain", idle, 1);

        // R3: only auto-flow set, queue enable clear: still sends
        auto_flow_en = 1'b1;
        put_byte(8'h5A);
        wait_stops(4);
        check(stops_seen == 4, "R3 single enable no gating", stops_seen, 4);

        // R4/R6: both enables set, cts_n high, nothing starts
        fifo_en = 1'b1;
        repeat (10) @(negedge clk);
        put_byte(8'h01);
        put_byte(8'hFE);
        repeat (1500) @(negedge clk);
        check(stops_seen == 4, "R4 halted no frame", stops_seen, 4);
        check(txd == 1'b1, "R4 line high while halted", txd, 1);
        check(fifo_level == 2, "R6 level while halted", fifo_level, 2);
        check(idle == 1'b0, "R9 not idle with data", idle, 0);

        // R8: release resumes
        cts_n = 1'b0;
        wait_stops(6);
        repeat (100) @(negedge clk);
        check(stops_seen == 6, "R8 resumed", stops_seen, 6);
        check(fifo_level == 0, "R8 drained", fifo_level, 0);

        // R5: cts_n rises just after mid stop bit of frame 1 -> frame 2 still goes
        base = stops_seen;
        put_byte(8'hC3);
        put_byte(8'h7E);
        put_byte(8'h99);
        wait_stops(base + 1);
        repeat (16) @(negedge clk);
        cts_n = 1'b1;
        wait_stops(base + 2);
        repeat (1500) @(negedge clk);
        check(stops_seen == base + 2, "R5 one more frame then halt", stops_seen, base + 2);
        check(fifo_level == 1, "R5 one byte left", fifo_level, 1);
        cts_n = 1'b0;
        wait_stops(base + 3);
        check(stops_seen == base + 3, "R8 resumed after late halt", stops_seen, base + 3);

        // R6/R7: fill while halted, then overflow
        repeat (100) @(negedge clk);
        cts_n = 1'b1;
        repeat (10) @(negedge clk);
        base = stops_seen;
        for (int i = 0; i < 16; i++) put_byte(8'(i * 17 + 3));
        check(fifo_level == 16, "R6 level full", fifo_level, 16);
        check(fifo_not_full == 1'b0, "R6 not_full low", fifo_not_full, 0);
        check(overflow == 1'b0, "R7 no overflow yet", overflow, 0);
        put_dropped(8'hEE);
        check(overflow == 1'b1, "R7 overflow set", overflow, 1);
        check(fifo_level == 16, "R7 level unchanged", fifo_level, 16);
        cts_n = 1'b0;
        wait_stops(base + 16);
        repeat (100) @(negedge clk);
        check(stops_seen == base + 16, "R7 dropped byte not sent", stops_seen, base + 16);
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
        check(idle == 1'b1, "R9 idle at end", idle, 1);
        check(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule